// File: doc/BRIEF.md
# Oversampled Serial Receive Engine with Break Handling

This block turns an asynchronous serial input into characters. The line is synchronised and then sampled on a 16x baud tick. A start bit is accepted only if the line is still low at its mid-bit sample. Between five and eight data bits are then shifted in, least significant bit first, followed by an optional parity bit and one stop bit. Each finished character goes to a receive buffer through a one-clock strobe. The strobe carries the data and three status tags: parity error, framing error and break.

Two cases are handled without a new falling edge. A zero in the stop position is reported as a framing error, and that zero is then taken as the start bit of the next character. A line held low past a full word time is reported as a single all-zero break character. The engine then ignores the line until it has stayed high for half a bit.

Word length, parity enable and parity sense are captured when a start bit is first seen. They hold for the whole of that character.

Top module: `serial_rx_engine`

## Requirements
- R1: While `rst` is high, and in the first clock after it, `rx_valid`, `rx_data` and all three tags are zero. Reset abandons any character in progress.
- R2: A start bit is accepted only if the synchronised line is low at the 8th tick sample after the first low sample. A low pulse of 7 tick samples or less produces no character.
- R3: `word_len` selects the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits arrive LSB first and land in `rx_data[0]` upward, and unused upper bits read as zero.
- R4: With `parity_en`=1, one parity bit follows the data. `rx_perr` is set when the data ones plus the parity bit give an odd count with `parity_even`=1, or an even count with `parity_even`=0. With `parity_en`=0 no parity bit is expected and `rx_perr` stays 0.
- R5: A 1 sampled in the stop position produces a character with `rx_ferr`=0. A 0 there produces `rx_ferr`=1.
- R6: After a framing error on a character that is not all zero, the low stop bit is sampled once more on the next tick. If it is still low it is used as the start bit, and data bits are taken 16 ticks apart from its middle with no new falling edge.
- R7: If start, data, parity and stop are all low and the line stays low for 9 more tick samples past the stop sample, exactly one character is pushed: `rx_data`=0, `rx_brk`=1, `rx_ferr`=0, `rx_perr`=0. This holds however long the low lasts.
- R8: After a break, no start bit is looked for until 8 consecutive high tick samples have been seen. Any low sample restarts that count and produces no character.
- R9: `rx_valid` is high for exactly one clock per character and is never high on two clocks in a row.
- R10: An all-zero character whose low stop is followed by a high within 8 tick samples of the stop sample is pushed as a framing error with `rx_brk`=0. A high sample counts only when it arrives on a tick.
- R11: The engine advances only on clocks where `baud_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-clock pulse at 16x the bit rate |
| rxd | input | 1 | Asynchronous serial input, idle high |
| word_len | input | 2 | Data length code, 0..3 = 5..8 bits |
| parity_en | input | 1 | Expect a parity bit after the data |
| parity_even | input | 1 | 1 = even parity, 0 = odd parity |
| rx_valid | output | 1 | One-clock character strobe |
| rx_data | output | DATA_W (8) | Received character, upper bits zero |
| rx_perr | output | 1 | Parity error tag |
| rx_ferr | output | 1 | Framing error tag |
| rx_brk | output | 1 | Break tag |

## Verification
The bench uses the default parameters: 16 samples per bit, an 8-bit data path and a two-stage synchroniser. It drives `baud_tick` only on every second clock, so R11 gating is exercised on every bit. With these values all four word lengths and both parity senses can be reached. The timing windows are short enough to check exactly: the 8-sample start check, the 9-sample break window and the 8-sample re-arm window. Each can be hit one sample inside or outside its boundary.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_RESYNC,
    ST_BRKCHK,
    ST_BRKWAIT,
    ST_REARM
  } rx_state_e;

  typedef struct packed {
    logic perr;
    logic ferr;
    logic brk;
  } rx_tag_t;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int   STAGES   = 2,
  parameter logic IDLE_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= IDLE_VAL;
          else     chain_q[g] <= din;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= IDLE_VAL;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/rx_char_pack.sv
module rx_char_pack #(
  parameter int DW = 8,
  parameter int BW = 4
) (
  input  logic [DW-1:0] shreg,
  input  logic [BW-1:0] nbits,
  output logic [DW-1:0] data,
  output logic          ones_odd
);
  // The shift register fills from the top, so a short word sits in the
  // upper bits. Move it down to bit 0 and clear the rest.
  always_comb begin
    data = '0;
    for (int i = 0; i < DW; i++) begin
      if (i < int'(nbits)) data[i] = shreg[i + DW - int'(nbits)];
    end
  end

  assign ones_odd = ^data;
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import uart_rx_pkg::*;
#(
  parameter int OSR      = 16,
  parameter int DW       = 8,
  parameter int LW       = 2,
  parameter int MIN_BITS = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          rx,
  input  logic [LW-1:0] word_len,
  input  logic          par_en,
  input  logic          par_even,
  output logic          valid_q,
  output logic [DW-1:0] data_q,
  output rx_tag_t       tag_q
);
  localparam int CW   = $clog2(OSR);
  localparam int BW   = $clog2(DW + 1);
  localparam int HALF = OSR / 2;

  rx_state_e     st_q;
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] bitn_q;
  logic [DW-1:0] shreg_q;
  logic          zero_q;
  logic          par_bit_q;
  logic [LW-1:0] wl_q;
  logic          pen_q;
  logic          pev_q;

  logic [BW-1:0] nbits;
  logic [DW-1:0] pk_data;
  logic          pk_odd;
  logic          perr_now;

  assign nbits = BW'(MIN_BITS) + BW'(wl_q);

  rx_char_pack #(.DW(DW), .BW(BW)) u_pack (
    .shreg    (shreg_q),
    .nbits    (nbits),
    .data     (pk_data),
    .ones_odd (pk_odd)
  );

  // even: total ones must be even; odd: total ones must be odd
  assign perr_now = pen_q & (pk_odd ^ par_bit_q ^ ~pev_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      bitn_q    <= '0;
      shreg_q   <= '0;
      zero_q    <= 1'b1;
      par_bit_q <= 1'b0;
      wl_q      <= '0;
      pen_q     <= 1'b0;
      pev_q     <= 1'b0;
      valid_q   <= 1'b0;
      data_q    <= '0;
      tag_q     <= '0;
    end else begin
      valid_q <= 1'b0;
      if (tick) begin
        unique case (st_q)
          ST_IDLE: begin
            if (!rx) begin
              st_q      <= ST_START;
              cnt_q     <= CW'(1);
              wl_q      <= word_len;
              pen_q     <= par_en;
              pev_q     <= par_even;
              par_bit_q <= 1'b0;
            end
          end
          ST_START: begin
            if (cnt_q == CW'(HALF - 1)) begin
              if (rx) begin
                st_q <= ST_IDLE;
              end else begin
                st_q   <= ST_DATA;
                cnt_q  <= '0;
                bitn_q <= '0;
                zero_q <= 1'b1;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_DATA: begin
            if (cnt_q == CW'(OSR - 1)) begin
              cnt_q   <= '0;
              shreg_q <= {rx, shreg_q[DW-1:1]};
              zero_q  <= zero_q & ~rx;
              bitn_q  <= bitn_q + 1'b1;
              if (bitn_q == nbits - 1'b1) st_q <= pen_q ? ST_PAR : ST_STOP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_PAR: begin
            if (cnt_q == CW'(OSR - 1)) begin
              cnt_q     <= '0;
              par_bit_q <= rx;
              zero_q    <= zero_q & ~rx;
              st_q      <= ST_STOP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_STOP: begin
            if (cnt_q == CW'(OSR - 1)) begin
              cnt_q <= '0;
              if (rx) begin
                valid_q <= 1'b1;
                data_q  <= pk_data;
                tag_q   <= '{perr: perr_now, ferr: 1'b0, brk: 1'b0};
                st_q    <= ST_IDLE;
              end else if (zero_q) begin
                st_q <= ST_BRKCHK;
              end else begin
                valid_q <= 1'b1;
                data_q  <= pk_data;
                tag_q   <= '{perr: perr_now, ferr: 1'b1, brk: 1'b0};
                st_q    <= ST_RESYNC;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_RESYNC: begin
            if (!rx) begin
              st_q      <= ST_DATA;
              cnt_q     <= CW'(1);
              bitn_q    <= '0;
              zero_q    <= 1'b1;
              par_bit_q <= 1'b0;
            end else begin
              st_q <= ST_IDLE;
            end
          end
          ST_BRKCHK: begin
            if (rx) begin
              valid_q <= 1'b1;
              data_q  <= pk_data;
              tag_q   <= '{perr: perr_now, ferr: 1'b1, brk: 1'b0};
              st_q    <= ST_IDLE;
            end else if (cnt_q == CW'(HALF)) begin
              valid_q <= 1'b1;
              data_q  <= '0;
              tag_q   <= '{perr: 1'b0, ferr: 1'b0, brk: 1'b1};
              st_q    <= ST_BRKWAIT;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_BRKWAIT: begin
            if (rx) begin
              st_q  <= ST_REARM;
              cnt_q <= CW'(1);
            end
          end
          ST_REARM: begin
            if (!rx)                         cnt_q <= '0;
            else if (cnt_q == CW'(HALF - 1)) st_q  <= ST_IDLE;
            else                             cnt_q <= cnt_q + 1'b1;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  p_state_gated_r11: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(st_q))
    else $error("state moved without a baud tick");

  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q)
    else $error("character strobe longer than one clock");

  p_break_tags_r7: assert property (@(posedge clk) disable iff (rst)
    (valid_q && tag_q.brk) |-> (data_q == '0 && !tag_q.ferr && !tag_q.perr))
    else $error("break character malformed");

  p_perr_needs_en_r4: assert property (@(posedge clk) disable iff (rst)
    (valid_q && tag_q.perr) |-> pen_q)
    else $error("parity error with parity disabled");

  p_upper_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (valid_q && wl_q == '0) |-> (data_q[DW-1:MIN_BITS] == '0))
    else $error("upper data bits not cleared");

  p_rearm_silent_r8: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_REARM || st_q == ST_BRKWAIT) |=> !valid_q)
    else $error("push while waiting for idle after break");

  p_break_leaves_r7: assert property (@(posedge clk) disable iff (rst)
    (valid_q && tag_q.brk) |-> (st_q == ST_BRKWAIT))
    else $error("break pushed outside break handling");
endmodule

// File: rtl/serial_rx_engine.sv
module serial_rx_engine
  import uart_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int DATA_W      = 8,
  parameter int LEN_W       = 2,
  parameter int MIN_BITS    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              rxd,
  input  logic [LEN_W-1:0]  word_len,
  input  logic              parity_en,
  input  logic              parity_even,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_perr,
  output logic              rx_ferr,
  output logic              rx_brk
);
  logic    rx_s;
  rx_tag_t tag;

  rx_line_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (rxd),
    .dout (rx_s)
  );

  rx_frame_fsm #(
    .OSR      (OSR),
    .DW       (DATA_W),
    .LW       (LEN_W),
    .MIN_BITS (MIN_BITS)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .tick     (baud_tick),
    .rx       (rx_s),
    .word_len (word_len),
    .par_en   (parity_en),
    .par_even (parity_even),
    .valid_q  (rx_valid),
    .data_q   (rx_data),
    .tag_q    (tag)
  );

  assign rx_perr = tag.perr;
  assign rx_ferr = tag.ferr;
  assign rx_brk  = tag.brk;

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!rx_valid && rx_data == '0 && !rx_perr && !rx_ferr && !rx_brk))
    else $error("outputs not cleared by reset");
endmodule

// File: tb/serial_rx_engine_tb.sv
module serial_rx_engine_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] word_len = 2'd3;
  logic       parity_en = 1'b0;
  logic       parity_even = 1'b0;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       rx_perr, rx_ferr, rx_brk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0] cap_d [64];
  logic [2:0] cap_t [64];
  int n_cap = 0;
  int dbl = 0;
  logic prev_v = 1'b0;

  always #10 clk = ~clk;

  serial_rx_engine u_dut (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .rxd(rxd),
    .word_len(word_len), .parity_en(parity_en), .parity_even(parity_even),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk)
  );

  // tick on every second clock
  always @(negedge clk) baud_tick <= rst ? 1'b0 : ~baud_tick;

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid && prev_v) dbl++;
      if (rx_valid && n_cap < 64) begin
        cap_d[n_cap] = rx_data;
        cap_t[n_cap] = {rx_perr, rx_ferr, rx_brk};
        n_cap++;
      end
      prev_v = rx_valid;
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick_wait(int n);
    repeat (n) begin
      @(posedge clk);
      while (!baud_tick) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic bit_out(logic v, int n = 16);
    rxd = v;
    tick_wait(n);
  endtask

  // start, data LSB first, optional parity (stop is left to the caller)
  task automatic send_body(logic [1:0] wl, logic pen, logic pev, logic bad, logic [7:0] d);
    int nb;
    logic ones;
    nb = 5 + int'(wl);
    word_len = wl; parity_en = pen; parity_even = pev;
    ones = 1'b0;
    for (int i = 0; i < nb; i++) ones ^= d[i];
    bit_out(1'b0);
    for (int i = 0; i < nb; i++) bit_out(d[i]);
    if (pen) bit_out((pev ? ones : ~ones) ^ bad);
  endtask

  task automatic expect_char(string req, int base, int idx, logic [7:0] d, logic pe, logic fe, logic bk);
    check({req, " data"}, int'(cap_d[base+idx]), int'(d));
    check({req, " tags"}, int'(cap_t[base+idx]), int'({pe, fe, bk}));
  endtask

  // {word_len[1:0], parity_en, parity_even, bad_parity, data[7:0]}
  localparam logic [12:0] VEC [9] = '{
    {2'd3, 1'b0, 1'b0, 1'b0, 8'hA5},
    {2'd0, 1'b0, 1'b0, 1'b0, 8'hFF},
    {2'd1, 1'b1, 1'b1, 1'b0, 8'h2D},
    {2'd2, 1'b1, 1'b0, 1'b0, 8'h55},
    {2'd3, 1'b1, 1'b1, 1'b1, 8'h81},
    {2'd3, 1'b1, 1'b0, 1'b1, 8'h7E},
    {2'd0, 1'b1, 1'b0, 1'b0, 8'h13},
    {2'd3, 1'b0, 1'b0, 1'b0, 8'h00},
    {2'd2, 1'b1, 1'b1, 1'b1, 8'h40}
  };

  initial begin
    int base;
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1 valid", int'(rx_valid), 0);
    check("R1 data", int'(rx_data), 0);
    check("R1 tags", int'({rx_perr, rx_ferr, rx_brk}), 0);
    rst = 1'b0;
    tick_wait(40);

    // R3 R4 R5 R9 R11: table walk
    for (int v = 0; v < 9; v++) begin
      logic [1:0] wl;
      logic pen, pev, bad;
      logic [7:0] d, m;
      {wl, pen, pev, bad, d} = VEC[v];
      m = d & 8'((9'd1 << (5 + int'(wl))) - 9'd1);
      base = n_cap;
      send_body(wl, pen, pev, bad, d);
      bit_out(1'b1, 40);
      check("R3 R11 push count", n_cap - base, 1);
      expect_char("R3 R4 R5", base, 0, m, pen & bad, 1'b0, 1'b0);
    end

    // R2: 7-sample glitch ignored
    base = n_cap;
    bit_out(1'b0, 7);
    bit_out(1'b1, 200);
    check("R2 glitch no push", n_cap - base, 0);

    // R5 R6: bad stop, then resync on it without a new edge
    base = n_cap;
    send_body(2'd3, 1'b0, 1'b0, 1'b0, 8'h5A);
    bit_out(1'b0);
    for (int i = 0; i < 8; i++) bit_out(8'h3C >> i);
    bit_out(1'b1, 60);
    check("R6 push count", n_cap - base, 2);
    expect_char("R5 ferr char", base, 0, 8'h5A, 1'b0, 1'b1, 1'b0);
    expect_char("R6 resync char", base, 1, 8'h3C, 1'b0, 1'b0, 1'b0);

    // R10: all-zero char with short low stop is a framing error
    base = n_cap;
    send_body(2'd3, 1'b0, 1'b0, 1'b0, 8'h00);
    bit_out(1'b0);
    bit_out(1'b1, 60);
    check("R10 push count", n_cap - base, 1);
    expect_char("R10 not break", base, 0, 8'h00, 1'b0, 1'b1, 1'b0);

    // R7: long break gives exactly one zero char
    base = n_cap;
    bit_out(1'b0, 16 * 30);
    check("R7 single break push", n_cap - base, 1);
    expect_char("R7 break char", base, 0, 8'h00, 1'b0, 1'b0, 1'b1);

    // R8: short high then low does not re-arm
    base = n_cap;
    bit_out(1'b1, 4);
    bit_out(1'b0, 24);
    bit_out(1'b1, 40);
    check("R8 no push before rearm", n_cap - base, 0);
    base = n_cap;
    send_body(2'd3, 1'b1, 1'b1, 1'b0, 8'hC3);
    bit_out(1'b1, 40);
    check("R8 push after rearm", n_cap - base, 1);
    expect_char("R8 char after rearm", base, 0, 8'hC3, 1'b0, 1'b0, 1'b0);

    // R1: reset abandons a frame in progress
    base = n_cap;
    bit_out(1'b0, 40);
    rst = 1'b1;
    rxd = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    tick_wait(40);
    check("R1 no push after mid-frame reset", n_cap - base, 0);
    base = n_cap;
    send_body(2'd1, 1'b0, 1'b0, 1'b0, 8'h2A);
    bit_out(1'b1, 40);
    check("R1 push after reset", n_cap - base, 1);
    expect_char("R1 R3 char after reset", base, 0, 8'h2A, 1'b0, 1'b0, 1'b0);

    // R9: never two strobes in a row
    check("R9 back-to-back strobes", dbl, 0);

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule